// File: doc/BRIEF.md
# Shadowed BCD Calendar Clock Registers

This block keeps a calendar and time of day in 24-hour BCD and advances it once for every cycle in which a one-second enable is high. The host reaches it through a small synchronous byte port. The port covers the top eight addresses of a 2K-byte space. The host never touches the running counters directly. It reads and writes a set of holding bytes. After every change of the live time, a small state machine copies the live counters into the holding bytes, all in one cycle.

Two halt bits in the control byte change how the holding bytes behave:
- **Read halt** freezes the holding bytes, so the host can read a consistent snapshot.
- **Write halt** opens the holding bytes to host writes. When this bit is cleared, the holding bytes are moved into the live counters.

Neither halt stops the counters themselves. A stop bit in the seconds byte gates the one-second enable.

The state machine has five states:
- **IDLE**: holding bytes track the live time.
- **COPY**: the one-cycle refresh.
- **RHALT**: snapshot frozen.
- **WHALT**: holding bytes open to the host.
- **LOAD**: one-cycle transfer into the counters.

Its transitions are:
- IDLE→COPY on any live update.
- IDLE→WHALT or IDLE→RHALT on a halt bit, with write halt taking priority.
- COPY→COPY while updates keep arriving.
- COPY→WHALT, COPY→RHALT or COPY→IDLE once the copy is done.
- RHALT→WHALT when write halt is set.
- RHALT→COPY when read halt clears.
- WHALT→LOAD when write halt clears.
- LOAD→COPY.

A pending refresh always completes before a halt takes effect.

Top module: `rtc_shadow_top`

## Requirements
- R1: Byte addresses 0x7F8 to 0x7FF hold control, seconds, minutes, hours, day, date, month and year, in that order. A read returns its byte on `rdata` after the next rising edge, and `rdata` holds otherwise. Reads below 0x7F8 return 0x00. Control bits 5:0 are plain storage that reads back as written.
- R2: Seconds wrap from 59 to 00 and carry into minutes. Minutes wrap from 59 to 00 and carry into hours. Hours wrap from 23 to 00 and carry into day and date.
- R3: Day of week counts 1 to 7 and wraps from 7 to 1 at midnight.
- R4: Month length is applied automatically:
  - February has 28 days, or 29 when the year is divisible by four.
  - April, June, September and November have 30 days.
  - All other months have 31 days.
  - Month 12 wraps to 01 and carries into the year.
  - Year 99 wraps to 00.
- R5: While control bit 6 (read halt) is 1, reads of bytes 0x7F9 to 0x7FF return the time captured when it was set.
- R6: While control bit 7 (write halt) is 1, host writes go to the holding bytes. Clearing the bit loads all seven time fields into the counters, and counting continues from them.
- R7: The live time keeps advancing during a read halt. After the halt clears, reads show the advanced time within four cycles.
- R8: Bit 7 of the seconds byte is the stop bit. While it is 1, no field advances on the one-second enable.
- R9: Outside a write halt, a write to the seconds byte sets the live seconds and the stop bit directly.
- R10: Outside a write halt, writes to the minutes to year bytes have no effect.
- R11: Bits outside each field read as 0. The fields are seconds 6:0, minutes 6:0, hours 5:0, day 2:0, date 5:0, month 4:0 and year 7:0.
- R12: After reset, the control byte is 0x00 and the stop bit is 1. The time reads 00:00:00, day 1, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sec_tick | input | 1 | One-second advance enable, one cycle wide |
| cs | input | 1 | Access request |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |

## Verification
The bench goes after the rollover boundaries:
- midnight on the last day of a 30-day month, of February in leap and non-leap years, and of December 99. A design with a wrong month table or leap rule would land on a wrong date rather than on the 1st of the next month.

It freezes a snapshot, ticks underneath it and releases it. A design that refreshed during the halt, or that stopped the counters while halted, shows the wrong time before or after the release.

It also checks the following:
- the stop bit set at reset;
- a direct seconds write outside a halt;
- minutes writes that must be ignored;
- writes carrying stray upper bits, which a design without field masks would echo back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef struct packed {
        logic [7:0] year;
        logic [4:0] mon;
        logic [5:0] date;
        logic [2:0] day;
        logic [5:0] hour;
        logic [6:0] min;
        logic [6:0] sec;
    } rtc_time_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_COPY,
        S_RHALT,
        S_WHALT,
        S_LOAD
    } sync_state_e;

    localparam rtc_time_t RESET_TIME = '{year: 8'h00, mon: 5'h01, date: 6'h01,
                                         day: 3'd1, hour: 6'h00, min: 7'h00, sec: 7'h00};

    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

    function automatic logic [5:0] month_last(input logic [4:0] mon, input logic [7:0] year);
        logic leap;
        leap = year[4] ? (year[3:0] == 4'd2 || year[3:0] == 4'd6)
                       : (year[3:0] == 4'd0 || year[3:0] == 4'd4 || year[3:0] == 4'd8);
        if (mon == 5'h02)
            return leap ? 6'h29 : 6'h28;
        else if (mon == 5'h04 || mon == 5'h06 || mon == 5'h09 || mon == 5'h11)
            return 6'h30;
        else
            return 6'h31;
    endfunction

endpackage

// File: rtl/rtc_calendar.sv
module rtc_calendar
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      adv_en,
    input  logic      stop_i,
    input  logic      load_i,
    input  rtc_time_t load_val,
    input  logic      sec_wr,
    input  logic [6:0] sec_val,
    output rtc_time_t live_o,
    output logic      upd_o
);

    rtc_time_t cnt_q;
    rtc_time_t nxt;
    logic      go;
    logic [7:0] sec_i, min_i, hour_i, date_i, mon_i, year_i;
    logic [5:0] last_d;

    assign go    = adv_en && !stop_i;
    assign upd_o = load_i || sec_wr || go;

    always_comb begin
        sec_i  = bcd_inc({1'b0, cnt_q.sec});
        min_i  = bcd_inc({1'b0, cnt_q.min});
        hour_i = bcd_inc({2'b0, cnt_q.hour});
        date_i = bcd_inc({2'b0, cnt_q.date});
        mon_i  = bcd_inc({3'b0, cnt_q.mon});
        year_i = bcd_inc(cnt_q.year);
        last_d = month_last(cnt_q.mon, cnt_q.year);
        nxt    = cnt_q;
        if (cnt_q.sec != 7'h59) begin
            nxt.sec = sec_i[6:0];
        end else begin
            nxt.sec = 7'h00;
            if (cnt_q.min != 7'h59) begin
                nxt.min = min_i[6:0];
            end else begin
                nxt.min = 7'h00;
                if (cnt_q.hour != 6'h23) begin
                    nxt.hour = hour_i[5:0];
                end else begin
                    nxt.hour = 6'h00;
                    nxt.day  = (cnt_q.day == 3'd7) ? 3'd1 : cnt_q.day + 3'd1;
                    if (cnt_q.date != last_d) begin
                        nxt.date = date_i[5:0];
                    end else begin
                        nxt.date = 6'h01;
                        if (cnt_q.mon != 5'h12) begin
                            nxt.mon = mon_i[4:0];
                        end else begin
                            nxt.mon  = 5'h01;
                            nxt.year = (cnt_q.year == 8'h99) ? 8'h00 : year_i;
                        end
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= RESET_TIME;
        else if (load_i)
            cnt_q <= load_val;
        else if (sec_wr)
            cnt_q.sec <= sec_val;
        else if (go)
            cnt_q <= nxt;
    end

    assign live_o = cnt_q;

    assert_stop_freezes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !load_i && !sec_wr) |=> $stable(cnt_q));

    assert_sec_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !load_i && !sec_wr && cnt_q.sec == 7'h59) |=> (cnt_q.sec == 7'h00));

    assert_day_wrap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && !load_i && !sec_wr && cnt_q.sec == 7'h59 && cnt_q.min == 7'h59 &&
         cnt_q.hour == 6'h23 && cnt_q.day == 3'd7) |=> (cnt_q.day == 3'd1));

endmodule

// File: rtl/rtc_sync_fsm.sv
module rtc_sync_fsm
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       halt_rd,
    input  logic       halt_wr,
    input  logic       upd_i,
    input  rtc_time_t  live_i,
    input  logic       host_wr_en,
    input  logic [2:0] host_sel,
    input  logic [7:0] host_data,
    output rtc_time_t  hold_o,
    output logic       load_o,
    output logic       wr_open_o
);

    sync_state_e state_q, state_d;
    rtc_time_t   hold_q;
    logic        copy_en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (upd_i)        state_d = S_COPY;
                else if (halt_wr) state_d = S_WHALT;
                else if (halt_rd) state_d = S_RHALT;
            end
            S_COPY: begin
                if (upd_i)        state_d = S_COPY;
                else if (halt_wr) state_d = S_WHALT;
                else if (halt_rd) state_d = S_RHALT;
                else              state_d = S_IDLE;
            end
            S_RHALT: begin
                if (halt_wr)      state_d = S_WHALT;
                else if (!halt_rd) state_d = S_COPY;
            end
            S_WHALT: begin
                if (!halt_wr)     state_d = S_LOAD;
            end
            S_LOAD:               state_d = S_COPY;
            default:              state_d = S_IDLE;
        endcase
    end

    always_comb begin
        copy_en   = (state_q == S_COPY);
        load_o    = (state_q == S_LOAD);
        wr_open_o = (state_q == S_WHALT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= RESET_TIME;
        end else if (copy_en) begin
            hold_q <= live_i;
        end else if (wr_open_o && host_wr_en) begin
            case (host_sel)
                3'd1:    hold_q.sec  <= host_data[6:0];
                3'd2:    hold_q.min  <= host_data[6:0];
                3'd3:    hold_q.hour <= host_data[5:0];
                3'd4:    hold_q.day  <= host_data[2:0];
                3'd5:    hold_q.date <= host_data[5:0];
                3'd6:    hold_q.mon  <= host_data[4:0];
                3'd7:    hold_q.year <= host_data;
                default: ;
            endcase
        end
    end

    assign hold_o = hold_q;

    assert_rhalt_frozen_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_RHALT) |=> $stable(hold_q));

    assert_release_loads_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_WHALT && !halt_wr) |=> load_o);

    assert_load_copies_R6: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> (state_q == S_COPY));

    assert_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({copy_en, load_o, wr_open_o}));

endmodule

// File: rtl/rtc_shadow_top.sv
module rtc_shadow_top
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);

    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'((1 << ADDR_W) - 8);

    logic       in_win, wr_hit, rd_req;
    logic [2:0] idx;
    logic [7:0] ctl_q;
    logic       stop_q;
    logic       wr_open, load, upd, sec_live_wr;
    rtc_time_t  live, hold;
    logic [7:0] rd_byte;

    assign in_win      = (addr >= WIN_BASE);
    assign idx         = addr[2:0];
    assign wr_hit      = cs && we && in_win;
    assign rd_req      = cs && !we;
    assign sec_live_wr = wr_hit && (idx == 3'd1) && !wr_open;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q  <= 8'h00;
            stop_q <= 1'b1;
        end else if (wr_hit) begin
            if (idx == 3'd0) ctl_q  <= wdata;
            if (idx == 3'd1) stop_q <= wdata[7];
        end
    end

    rtc_calendar u_cal (
        .clk      (clk),
        .rst_n    (rst_n),
        .adv_en   (sec_tick),
        .stop_i   (stop_q),
        .load_i   (load),
        .load_val (hold),
        .sec_wr   (sec_live_wr),
        .sec_val  (wdata[6:0]),
        .live_o   (live),
        .upd_o    (upd)
    );

    rtc_sync_fsm u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .halt_rd    (ctl_q[6]),
        .halt_wr    (ctl_q[7]),
        .upd_i      (upd),
        .live_i     (live),
        .host_wr_en (wr_hit && idx != 3'd0),
        .host_sel   (idx),
        .host_data  (wdata),
        .hold_o     (hold),
        .load_o     (load),
        .wr_open_o  (wr_open)
    );

    always_comb begin
        unique case (idx)
            3'd0: rd_byte = ctl_q;
            3'd1: rd_byte = {stop_q, hold.sec};
            3'd2: rd_byte = {1'b0, hold.min};
            3'd3: rd_byte = {2'b0, hold.hour};
            3'd4: rd_byte = {5'b0, hold.day};
            3'd5: rd_byte = {2'b0, hold.date};
            3'd6: rd_byte = {3'b0, hold.mon};
            3'd7: rd_byte = hold.year;
            default: rd_byte = 8'h00;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata <= 8'h00;
        else if (rd_req)
            rdata <= in_win ? rd_byte : 8'h00;
    end

    assert_low_read_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !in_win) |=> (rdata == 8'h00));

    assert_rdata_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req |=> $stable(rdata));

    assert_seclive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sec_live_wr && !load) |=> (live.sec == $past(wdata[6:0])));

endmodule

// File: tb/tb_rtc_shadow_top.sv
module tb_rtc_shadow_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sec_tick = 1'b0;
    logic        cs = 1'b0;
    logic        we = 1'b0;
    logic [10:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  rdata;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // model: index 0 sec,1 min,2 hour,3 day,4 date,5 month,6 year (decimal)
    int lv[7];
    int hd[7];
    int stop_m;
    int ctl_m;
    int fmask[8] = '{8'hFF, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_shadow_top dut (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .cs(cs), .we(we),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    function automatic int bcd(int v);
        return ((v / 10) << 4) | (v % 10);
    endfunction

    function automatic int dec(int b);
        return (b >> 4) * 10 + (b & 15);
    endfunction

    function automatic int mlen(int mo, int y);
        if (mo == 2) return (y % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    function automatic bit halted();
        return (ctl_m & 8'hC0) != 0;
    endfunction

    function automatic int exp_byte(int a);
        int v;
        if (a < 12'h7F8) return 0;
        if (a == 12'h7F8) return ctl_m;
        v = halted() ? hd[a - 12'h7F9] : lv[a - 12'h7F9];
        if (a == 12'h7F9) return (stop_m << 7) | bcd(v);
        return bcd(v);
    endfunction

    task automatic advance_model();
        if (stop_m != 0) return;
        lv[0]++;
        if (lv[0] == 60) begin
            lv[0] = 0; lv[1]++;
            if (lv[1] == 60) begin
                lv[1] = 0; lv[2]++;
                if (lv[2] == 24) begin
                    lv[2] = 0;
                    lv[3] = (lv[3] == 7) ? 1 : lv[3] + 1;
                    lv[4]++;
                    if (lv[4] > mlen(lv[5], lv[6])) begin
                        lv[4] = 1; lv[5]++;
                        if (lv[5] == 13) begin
                            lv[5] = 1; lv[6] = (lv[6] + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_write(int a, int d);
        @(negedge clk);
        cs = 1'b1; we = 1'b1; addr = 11'(a); wdata = 8'(d);
        @(negedge clk);
        cs = 1'b0; we = 1'b0;
    endtask

    task automatic wr_ctl(int d);
        bit was_h, was_w;
        was_h = halted();
        was_w = (ctl_m & 8'h80) != 0;
        bus_write(12'h7F8, d);
        if (!was_h && (d & 8'hC0) != 0) hd = lv;
        if (was_w && (d & 8'h80) == 0) lv = hd;
        ctl_m = d;
        settle();
    endtask

    task automatic wr_field(int i, int d);
        bus_write(12'h7F8 + i, d);
        if (i == 1) begin
            stop_m = (d >> 7) & 1;
            if ((ctl_m & 8'h80) != 0) hd[0] = dec(d & 8'h7F);
            else lv[0] = dec(d & 8'h7F);
        end else if ((ctl_m & 8'h80) != 0) begin
            hd[i - 1] = dec(d & fmask[i]);
        end
        settle();
    endtask

    task automatic tick();
        @(negedge clk);
        sec_tick = 1'b1;
        @(negedge clk);
        sec_tick = 1'b0;
        advance_model();
        settle();
    endtask

    task automatic chk_read(int a, string req);
        int e;
        e = exp_byte(a);
        @(negedge clk);
        cs = 1'b1; we = 1'b0; addr = 11'(a);
        @(negedge clk);
        cs = 1'b0;
        checks++;
        if (int'(rdata) != e) begin
            fails++;
            $display("FAIL %s addr=%03h actual=%02h expected=%02h", req, a, rdata, e);
        end
    endtask

    task automatic read_all(string req);
        for (int k = 0; k < 8; k++) chk_read(12'h7F8 + k, req);
    endtask

    task automatic load_time(int yr, int mo, int dt, int dy, int hr, int mi, int se);
        wr_ctl(8'h80);
        wr_field(1, bcd(se));
        wr_field(2, bcd(mi));
        wr_field(3, bcd(hr));
        wr_field(4, bcd(dy));
        wr_field(5, bcd(dt));
        wr_field(6, bcd(mo));
        wr_field(7, bcd(yr));
        wr_ctl(8'h00);
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            report();
        end
    end

    initial begin
        lv = '{0, 0, 0, 1, 1, 1, 0};
        hd = lv;
        stop_m = 1;
        ctl_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();

        // R12: reset values, stop set
        read_all("R12 reset");

        // R8: stop bit holds the time
        tick();
        chk_read(12'h7F9, "R8 stopped");

        // R9: direct seconds write clears stop
        wr_field(1, 8'h58);
        chk_read(12'h7F9, "R9 direct sec");

        // R2: seconds carry into minutes
        tick(); tick();
        chk_read(12'h7F9, "R2 sec wrap");
        chk_read(12'h7FA, "R2 min carry");

        // R10: minutes write ignored outside a write halt
        wr_field(2, 8'h30);
        chk_read(12'h7FA, "R10 ignored");

        // R11 masks, R6 load: stray bits on hours and day
        wr_ctl(8'h80);
        wr_field(3, 8'hE3);
        wr_field(4, 8'h47);
        chk_read(12'h7FB, "R11 hour mask");
        chk_read(12'h7FC, "R11 day mask");
        wr_ctl(8'h00);

        // R2 R3 R4: non-leap February end rolls to March
        load_time(3, 2, 28, 7, 23, 59, 58);
        read_all("R6 loaded");
        tick(); tick();
        read_all("R4 feb nonleap");
        chk_read(12'h7FC, "R3 day wrap");

        // R4: leap year
        load_time(4, 2, 28, 3, 23, 59, 59);
        tick();
        read_all("R4 feb leap 29");
        load_time(4, 2, 29, 4, 23, 59, 59);
        tick();
        read_all("R4 leap to march");

        // R4: 30-day month and year wrap
        load_time(21, 4, 30, 5, 23, 59, 59);
        tick();
        read_all("R4 april end");
        load_time(99, 12, 31, 6, 23, 59, 59);
        tick();
        read_all("R4 year wrap");

        // R5 R7: read halt freezes snapshot while time runs
        wr_ctl(8'h40);
        tick(); tick(); tick();
        read_all("R5 snapshot");
        wr_ctl(8'h00);
        read_all("R7 resumed");

        // R8: stop again via direct write, ticks do nothing
        wr_field(1, 8'h80 | bcd(lv[0]));
        tick();
        read_all("R8 stop set");

        // R1: low address, control storage bits
        chk_read(12'h123, "R1 low addr");
        wr_ctl(8'h15);
        chk_read(12'h7F8, "R1 ctl bits");
        wr_ctl(8'h00);

        done = 1;
        report();
    end

endmodule